// File: doc/BRIEF.md
# Receive Line Decoder with Violation Flag

This block is the digital back end of one receive channel. Each cycle of the recovered clock it takes a pair of mark indicators, one for a positive pulse and one for a negative pulse on the line. In dual-rail mode the two indicators pass through unchanged. In single-rail mode the block decodes the line code to NRZ data on the positive output and turns the negative output into a one-cycle error flag.

Three line codes are supported in single-rail mode: plain AMI, B8ZS for T1 and HDB3 for E1. The two zero-substitution codes have their substitution patterns recognised and replaced by zeros. The error flag reports bipolar violations, HDB3 violations that fail to alternate, invalid symbols and runs of zeros longer than the code allows. Recognising a B8ZS pattern takes eight symbols, so every symbol passes through an eight-stage window. The latency is the same in every mode.

The output clock is the receive clock, optionally inverted, so that downstream logic can capture on either edge.

Top module: `rx_line_decoder`

## Requirements
- R1: Latency is eight cycles in every mode. A symbol sampled at rising edge k is on `pos_o`/`neg_o` from just after rising edge k+7 until edge k+8.
- R2: AMI single-rail (`ami_i`=1): `pos_o` is 1 for a mark on either rail alone and 0 otherwise. `neg_o` is 1 only for a mark of the same polarity as the previous mark, and that mark still decodes to 1. Substitution patterns are not removed in AMI.
- R3: HDB3 (`ami_i`=0, `e1_i`=1): a mark of the same polarity as the previous mark, preceded by two spaces, is a substitution. It decodes to 0 without a flag. A mark three symbols before it is also decoded to 0.
- R4: HDB3: a substitution mark with the same polarity as the previous violation mark raises `neg_o` at its own position.
- R5: B8ZS (`ami_i`=0, `e1_i`=0): the sequence 0,0,0,V,B,0,V,B decodes to eight zeros with no flag. Here V repeats the previous mark's polarity and B alternates.
- R6: In single-rail mode, the (N+1)th consecutive space raises `neg_o` once per run, with N = 3 for HDB3, 7 for B8ZS and 15 for AMI. Any mark restarts the count.
- R7: In single-rail mode, a symbol with both rails high decodes to 0, raises `neg_o`, and counts as a space for R6. When it is also the (N+1)th space, `neg_o` is high for that single cycle only.
- R8: Under HDB3 or B8ZS, a same-polarity mark that is not part of a substitution decodes to 1 and raises `neg_o`.
- R9: `rclk_o` equals `clk_i` when `rclk_inv_i`=0 and its inverse when `rclk_inv_i`=1.
- R10: While `rst_ni` is low, `pos_o` and `neg_o` are 0. After reset, no mark polarity history remains, so the first mark is never flagged.
- R11: In dual-rail mode (`dual_rail_i`=1), `pos_o`/`neg_o` copy `pos_i`/`neg_i` including the both-high case. No decoding or flagging takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered receive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dual_rail_i | input | 1 | 1: rails pass through; 0: single-rail decode |
| ami_i | input | 1 | 1: AMI code; 0: zero-substitution code |
| e1_i | input | 1 | With ami_i=0: 1 selects HDB3, 0 selects B8ZS |
| rclk_inv_i | input | 1 | Inverts the output clock |
| pos_i | input | 1 | Positive mark indicator |
| neg_i | input | 1 | Negative mark indicator |
| pos_o | output | 1 | Positive rail or NRZ data |
| neg_o | output | 1 | Negative rail or error flag |
| rclk_o | output | 1 | Output clock, optionally inverted |

## Verification
The invalid-symbol check and the excessive-zero check can fire on the same symbol. The bench provokes this under HDB3 by driving three spaces after a mark and then a both-rails symbol, followed by one more space. The expected output is a single flagged cycle at the invalid symbol and no flag on the space that follows. A second overlap is in B8ZS: the two V marks are flagged when they arrive, and the closing B must withdraw those pending flags. The bench judges this by expecting eight unflagged zeros.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [1:0] {
    LC_AMI  = 2'd0,
    LC_B8ZS = 2'd1,
    LC_HDB3 = 2'd2
  } line_code_e;

  // mk: mark present (dual: positive rail), ng: negative polarity / rail, fl: error
  typedef struct packed {
    logic mk;
    logic ng;
    logic fl;
  } slot_t;
endpackage

// File: rtl/rxd_polarity.sv
module rxd_polarity (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic mark_i,
  input  logic neg_i,
  output logic viol_o,
  output logic vrep_o
);
  logic last_neg_q, have_mark_q, last_vneg_q, have_v_q;

  assign viol_o = en_i && mark_i && have_mark_q && (neg_i == last_neg_q);
  assign vrep_o = viol_o && have_v_q && (neg_i == last_vneg_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_neg_q  <= 1'b0;
      have_mark_q <= 1'b0;
      last_vneg_q <= 1'b0;
      have_v_q    <= 1'b0;
    end else if (!en_i) begin
      have_mark_q <= 1'b0;
      have_v_q    <= 1'b0;
    end else if (mark_i) begin
      last_neg_q  <= neg_i;
      have_mark_q <= 1'b1;
      if (viol_o) begin
        last_vneg_q <= neg_i;
        have_v_q    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxd_zero_run.sv
module rxd_zero_run
  import rxd_pkg::*;
#(
  parameter int AMI_LIM  = 15,
  parameter int B8ZS_LIM = 7,
  parameter int HDB3_LIM = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       space_i,
  input  line_code_e code_i,
  output logic       exz_o
);
  localparam int CW = $clog2(AMI_LIM + 2);
  localparam logic [CW-1:0] SAT = CW'(AMI_LIM + 1);

  logic [CW-1:0] cnt_q, lim;

  always_comb begin
    case (code_i)
      LC_HDB3: lim = CW'(HDB3_LIM);
      LC_B8ZS: lim = CW'(B8ZS_LIM);
      default: lim = CW'(AMI_LIM);
    endcase
  end

  assign exz_o = en_i && space_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || !space_i) cnt_q <= '0;
    else if (cnt_q != SAT)      cnt_q <= cnt_q + 1'b1;
  end

  // one flag per run of spaces
  assert_exz_once_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exz_o |=> !exz_o);
endmodule

// File: rtl/rxd_window.sv
module rxd_window
  import rxd_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dual_i,
  input  line_code_e code_i,
  input  logic       pos_i,
  input  logic       neg_i,
  input  logic       mark_i,
  input  logic       invalid_i,
  input  logic       viol_i,
  input  logic       vrep_i,
  input  logic       exz_i,
  output slot_t      out_o,
  output logic       hdb3_sub_o,
  output logic       b8zs_sub_o
);
  localparam int LAST = DEPTH - 1;

  slot_t st_q [DEPTH];
  slot_t w    [DEPTH];
  slot_t in_s;

  always_comb begin
    hdb3_sub_o = !dual_i && (code_i == LC_HDB3) && mark_i && viol_i &&
                 !st_q[0].mk && !st_q[1].mk;
    // 000VB0VB closes on the incoming B; both V slots carry pending flags
    b8zs_sub_o = !dual_i && (code_i == LC_B8ZS) && mark_i && !viol_i &&
                 st_q[0].mk && st_q[0].fl && !st_q[1].mk &&
                 st_q[2].mk && (st_q[2].ng == st_q[0].ng) &&
                 st_q[3].mk && st_q[3].fl && (st_q[3].ng != st_q[2].ng) &&
                 !st_q[4].mk && !st_q[5].mk && !st_q[6].mk;

    for (int i = 0; i < DEPTH; i++) w[i] = st_q[i];

    if (dual_i) begin
      in_s.mk = pos_i;
      in_s.ng = neg_i;
      in_s.fl = 1'b0;
    end else begin
      in_s.mk = mark_i && !hdb3_sub_o && !b8zs_sub_o;
      in_s.ng = neg_i;
      in_s.fl = invalid_i || exz_i || (hdb3_sub_o ? vrep_i : viol_i);
    end

    if (hdb3_sub_o) w[2].mk = 1'b0;
    if (b8zs_sub_o) begin
      w[0].mk = 1'b0;
      w[0].fl = 1'b0;
      w[2].mk = 1'b0;
      w[3].mk = 1'b0;
      w[3].fl = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= in_s;
      for (int i = 1; i < DEPTH; i++) st_q[i] <= w[i-1];
    end
  end

  assign out_o = st_q[LAST];

  // stages beyond the pattern window shift untouched
  assert_tail_intact_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q[LAST] == $past(st_q[LAST-1]));
endmodule

// File: rtl/rx_line_decoder.sv
module rx_line_decoder
  import rxd_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int AMI_LIM  = 15,
  parameter int B8ZS_LIM = 7,
  parameter int HDB3_LIM = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dual_rail_i,
  input  logic ami_i,
  input  logic e1_i,
  input  logic rclk_inv_i,
  input  logic pos_i,
  input  logic neg_i,
  output logic pos_o,
  output logic neg_o,
  output logic rclk_o
);
  line_code_e code;
  logic single, mark, invalid, space;
  logic viol, vrep, exz, hdb3_sub, b8zs_sub;
  slot_t out_s;

  assign code    = ami_i ? LC_AMI : (e1_i ? LC_HDB3 : LC_B8ZS);
  assign single  = !dual_rail_i;
  assign mark    = pos_i ^ neg_i;
  assign invalid = pos_i & neg_i;
  assign space   = !mark;

  rxd_polarity u_pol (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (single),
    .mark_i (mark),
    .neg_i  (neg_i),
    .viol_o (viol),
    .vrep_o (vrep)
  );

  rxd_zero_run #(
    .AMI_LIM  (AMI_LIM),
    .B8ZS_LIM (B8ZS_LIM),
    .HDB3_LIM (HDB3_LIM)
  ) u_zr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (single),
    .space_i (space),
    .code_i  (code),
    .exz_o   (exz)
  );

  rxd_window #(.DEPTH(DEPTH)) u_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dual_i     (dual_rail_i),
    .code_i     (code),
    .pos_i      (pos_i),
    .neg_i      (neg_i),
    .mark_i     (mark),
    .invalid_i  (invalid),
    .viol_i     (viol),
    .vrep_i     (vrep),
    .exz_i      (exz),
    .out_o      (out_s),
    .hdb3_sub_o (hdb3_sub),
    .b8zs_sub_o (b8zs_sub)
  );

  assign pos_o  = out_s.mk;
  assign neg_o  = dual_rail_i ? out_s.ng : out_s.fl;
  assign rclk_o = clk_i ^ rclk_inv_i;

  // edges since reset, bounds the $past depth of the checks below
  logic [2:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 3'd7) age_q <= age_q + 1'b1;
  end

  assert_hdb3_sub_spaces_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdb3_sub && age_q >= 3'd2 && $past(single) && $past(single, 2)) |->
    ((!$past(mark) || $past(hdb3_sub)) && (!$past(mark, 2) || $past(hdb3_sub, 2))));

  assert_b8zs_sub_viols_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b8zs_sub && age_q >= 3'd4 && $past(single) && $past(single, 4)) |->
    ($past(viol) && $past(viol, 4)));

  assert_dual_no_sub_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dual_rail_i |-> (!hdb3_sub && !b8zs_sub && !viol && !exz));
endmodule

// File: tb/tb_rx_line_decoder.sv
`timescale 1ns/100ps
module tb_rx_line_decoder;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic dual_rail = 1'b1, ami = 1'b0, e1 = 1'b0, rclk_inv = 1'b0;
  logic pos_i = 1'b0, neg_i = 1'b0;
  logic pos_o, neg_o, rclk_o;

  always #2.5 clk = ~clk;

  rx_line_decoder dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .dual_rail_i (dual_rail),
    .ami_i       (ami),
    .e1_i        (e1),
    .rclk_inv_i  (rclk_inv),
    .pos_i       (pos_i),
    .neg_i       (neg_i),
    .pos_o       (pos_o),
    .neg_o       (neg_o),
    .rclk_o      (rclk_o)
  );

  int total = 0, bad = 0;
  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  bit [1:0]    q_exp[$];
  int unsigned q_due[$];
  string       q_tag[$];

  task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b at cyc %0d", tag, act, exp, cyc);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (q_due.size() > 0 && q_due[0] == cyc) begin
      chk(q_tag[0], {pos_o, neg_o}, q_exp[0]);
      void'(q_exp.pop_front());
      void'(q_due.pop_front());
      void'(q_tag.pop_front());
    end
  end

  task automatic drive_sym(byte c, bit ep, bit ef, string tag);
    @(posedge clk); #1;
    pos_i = (c == "+") || (c == "x");
    neg_i = (c == "-") || (c == "x");
    q_exp.push_back({ep, ef});
    q_due.push_back(cyc + 8);
    q_tag.push_back(tag);
  endtask

  // line chars: + - 0 x ; expected chars: 0/1 (pos_o, neg_o)
  task automatic play(string ln, string ed, string ef, string tag);
    for (int i = 0; i < ln.len(); i++)
      drive_sym(ln[i], ed[i] == "1", ef[i] == "1", tag);
  endtask

  task automatic flush();
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #1;
      pos_i = 1'b0;
      neg_i = 1'b0;
    end
  endtask

  task automatic do_reset(bit d, bit a, bit e);
    @(posedge clk); #1;
    rst_ni = 1'b0;
    pos_i = 1'b0;
    neg_i = 1'b0;
    dual_rail = d;
    ami = a;
    e1 = e;
    @(posedge clk); #1;
    chk("R10", {pos_o, neg_o}, 2'b00);
    rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog expired at cyc %0d", cyc);
    finish_run();
  end

  initial begin
    // dual-rail pass-through, HDB3 selected but inactive
    do_reset(1'b1, 1'b0, 1'b1);
    play("+-0x", "1001", "0101", "R1");
    play("+00+", "1001", "0000", "R11");
    play("0000000000000000", "0000000000000000", "0000000000000000", "R11");
    play("-", "0", "1", "R11");
    flush();

    // AMI
    do_reset(1'b0, 1'b1, 1'b0);
    play("+-+--0+", "1111101", "0000100", "R2");
    play("0000000000000000", "0000000000000000", "0000000000000001", "R6");
    play("-", "1", "0", "R2");
    play("000000000000000", "000000000000000", "000000000000000", "R6");
    play("+", "1", "0", "R2");
    play("-00-", "1001", "0001", "R2");
    flush();

    // HDB3
    do_reset(1'b0, 1'b0, 1'b1);
    play("+-", "11", "00", "R3");
    play("000-", "0000", "0000", "R3");
    play("+", "1", "0", "R3");
    play("000+", "0000", "0000", "R3");
    play("-00-", "0000", "0000", "R3");
    play("+", "1", "0", "R3");
    play("-00-", "0000", "0001", "R4");
    play("++", "11", "01", "R8");
    play("0000", "0000", "0001", "R6");
    play("-", "1", "0", "R6");
    play("x", "0", "1", "R7");
    play("+", "1", "0", "R7");
    play("000x0-", "000001", "000100", "R7");
    flush();

    // B8ZS
    do_reset(1'b0, 1'b0, 1'b0);
    play("+-", "11", "00", "R5");
    play("000-+0+-", "00000000", "00000000", "R5");
    play("+", "1", "0", "R5");
    play("000+-0-+", "00000000", "00000000", "R5");
    play("--", "11", "01", "R8");
    play("00000000", "00000000", "00000001", "R6");
    play("+", "1", "0", "R6");
    play("0000000", "0000000", "0000000", "R6");
    play("-", "1", "0", "R6");
    flush();

    // polarity history cleared by reset: last mark before was negative
    do_reset(1'b0, 1'b1, 1'b0);
    play("-", "1", "0", "R10");
    flush();

    // output clock polarity
    rclk_inv = 1'b0;
    @(negedge clk); #0.5;
    chk("R9", {1'b0, rclk_o}, 2'b00);
    @(posedge clk); #1;
    chk("R9", {1'b0, rclk_o}, 2'b01);
    rclk_inv = 1'b1;
    @(negedge clk); #0.5;
    chk("R9", {1'b0, rclk_o}, 2'b01);
    @(posedge clk); #1;
    chk("R9", {1'b0, rclk_o}, 2'b00);

    repeat (3) @(posedge clk);
    if (q_due.size() != 0) begin
      total++;
      bad++;
      $display("FAIL R1 act=%0d pending exp=0", q_due.size());
    end
    finish_run();
  end
endmodule